// File: doc/BRIEF.md
# Up-Counting Alarm Timer

This block is a 32-bit timer that software reaches through a small register window of eight words. Once started, it counts upward on ticks from a prescaler that divides the core clock by 1, 16 or 256. The count wraps to zero after its top value and never stops on its own. An alarm register holds a compare value. When a tick moves the count onto that value, the block records an interrupt status bit and drives a one-cycle pulse on `irq` toward an interrupt controller.

Software sets the count directly by writing the load word. In reload mode, writing zero to the load word also freezes the counter, even when the run bit is set. The status bit either drops by itself after each event, or it is held until software clears it. In held mode, further interrupt pulses are suppressed while the status stays set. Reads of the status word, and of the three unused words at the top of the window, return the load word.

The register port is a plain single-cycle bus. A write takes effect at the clock edge where `bus_wr` is high. Read data is a combinational view of the addressed word after that edge. The port carries no handshake and never stalls.

Top module: `upcount_alarm_timer`

## Requirements
- R1: Control bits 3:2 choose the prescale. Code 0 gives one count step per clock, code 1 gives one step every 16 clocks, and codes 2 and 3 give one step every 256 clocks. The prescaler only runs while counting is enabled, and it restarts from zero after any load write.
- R2: Counting is enabled when control bit 7 (run) is set and the zero-load freeze is not active. The 32-bit count then rises by one on each prescaler tick and wraps from 0xFFFFFFFF to 0.
- R3: A match occurs when a tick moves the count onto the value in the alarm word (word 4, offset 0x10). A load write that lands on the alarm value is not a match. Each match asserts `irq` for exactly the one cycle in which the count first reads the alarm value, and it sets the status bit, which reads as control bit 8.
- R4: A write to the load word (word 0) stores the written value and replaces the live count with it in the same cycle. The load write takes priority over a tick in that cycle.
- R5: With control bit 6 (reload) set, a load write of zero clears the count and freezes counting. The freeze ends on the next nonzero load write, or on any control write that has bit 7 set. With bit 6 clear, a zero load write only clears the count.
- R6: When control bit 0 (hold) is set, the status bit stays set after a match until software writes zero to the status word (word 3). While the status is set, a further match raises no `irq` pulse. A nonzero write to the status word has no effect.
- R7: When control bit 0 is clear, the status bit drops one cycle after it was set, and every match raises an `irq` pulse.
- R8: Reads decode by word index: 0 returns load, 1 returns count, 2 returns control {status at bit 8, run at 7, reload at 6, divider at 3:2, hold at 0, other bits zero}, 3 returns load, 4 returns alarm, and 5, 6 and 7 return load.
- R9: A write to the count word (word 1) changes nothing.
- R10: Reset clears load, count, control, alarm, the status bit, the freeze and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_word | input | 3 | Word index within the window (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| irq | output | 1 | One-cycle interrupt pulse on a match |

## Verification
A register write is visible on `bus_rdata` in the cycle right after its clock edge. With divide-by-1, the first count step lands one edge after the run bit is written. The `irq` pulse appears in the same cycle as the count first reads the alarm value, and in non-hold mode the status bit drops one edge after that. The bench steps a behavioural model at each rising edge from the same inputs, then compares both `bus_rdata` and `irq` at every falling edge, so each result is checked in exactly the cycle where it is due. Frozen and idle states are also checked against fixed literal values.

// File: rtl/upcount_timer_pkg.sv
package upcount_timer_pkg;

  localparam int CNT_W    = 32;
  localparam int WORD_W   = 3;

  // word indices inside the register window
  localparam logic [WORD_W-1:0] WD_LOAD  = 3'd0;
  localparam logic [WORD_W-1:0] WD_COUNT = 3'd1;
  localparam logic [WORD_W-1:0] WD_CTRL  = 3'd2;
  localparam logic [WORD_W-1:0] WD_STAT  = 3'd3;
  localparam logic [WORD_W-1:0] WD_ALARM = 3'd4;

  // control field positions (software relies on these)
  localparam int CB_HOLD   = 0;
  localparam int CB_DIV_LO = 2;
  localparam int CB_RELOAD = 6;
  localparam int CB_RUN    = 7;
  localparam int CB_STATUS = 8;

  typedef enum logic [1:0] {
    PS_FAST = 2'd0,
    PS_MID  = 2'd1,
    PS_SLOW = 2'd2,
    PS_ALT  = 2'd3
  } prescale_e;

  typedef struct packed {
    logic      run;
    logic      reload;
    prescale_e div;
    logic      hold;
  } ctrl_t;

endpackage

// File: rtl/upcount_prescaler.sv
module upcount_prescaler #(
  parameter int MID_LOG2  = 4,
  parameter int SLOW_LOG2 = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en_i,
  input  logic                          clear_i,
  input  upcount_timer_pkg::prescale_e  div_i,
  output logic                          tick_o
);
  import upcount_timer_pkg::*;

  localparam int PRE_W = SLOW_LOG2;
  localparam logic [PRE_W-1:0] LIM_MID  = PRE_W'((1 << MID_LOG2) - 1);
  localparam logic [PRE_W-1:0] LIM_SLOW = PRE_W'((1 << SLOW_LOG2) - 1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] limit;

  always_comb begin
    unique case (div_i)
      PS_FAST: limit = '0;
      PS_MID:  limit = LIM_MID;
      default: limit = LIM_SLOW;
    endcase
  end

  // >= so that switching to a shorter period mid-way still ticks promptly
  assign tick_o = en_i && !clear_i && (pre_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pre_q <= '0;
    else if (clear_i || !en_i || tick_o) pre_q <= '0;
    else                             pre_q <= pre_q + 1'b1;
  end

  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && div_i != PS_FAST) |=> (!tick_o || div_i == PS_FAST));

endmodule

// File: rtl/upcount_counter.sv
module upcount_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             reload_i,
  input  logic             load_wr_i,
  input  logic [CNT_W-1:0] load_data_i,
  input  logic             run_set_i,
  input  logic [CNT_W-1:0] alarm_i,
  output logic [CNT_W-1:0] count_o,
  output logic             active_o,
  output logic             match_o
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_inc;
  logic             freeze_q;

  assign count_inc = count_q + 1'b1;
  assign active_o  = run_i && !freeze_q;
  assign count_o   = count_q;
  // compare only on the advancing step, never on a software load
  assign match_o   = tick_i && !load_wr_i && (count_inc == alarm_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         count_q <= '0;
    else if (load_wr_i) count_q <= load_data_i;
    else if (tick_i)    count_q <= count_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) freeze_q <= 1'b0;
    else if (load_wr_i) begin
      if (load_data_i != '0)  freeze_q <= 1'b0;
      else if (reload_i)      freeze_q <= 1'b1;
    end else if (run_set_i)   freeze_q <= 1'b0;
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_wr_i) |=> (count_q == $past(count_inc)));

  assert_load_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr_i |=> (count_q == $past(load_data_i)));

  assert_zero_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_wr_i && reload_i && load_data_i == '0) |=> (count_q == '0 && !active_o));

endmodule

// File: rtl/upcount_regs.sv
module upcount_regs #(
  parameter int CNT_W  = 32,
  parameter int WORD_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr_i,
  input  logic [WORD_W-1:0]          bus_word_i,
  input  logic [CNT_W-1:0]           bus_wdata_i,
  output logic [CNT_W-1:0]           bus_rdata_o,
  input  logic [CNT_W-1:0]           count_i,
  input  logic                       match_i,
  output upcount_timer_pkg::ctrl_t   ctrl_o,
  output logic [CNT_W-1:0]           alarm_o,
  output logic                       load_wr_o,
  output logic                       run_set_o,
  output logic                       irq_o
);
  import upcount_timer_pkg::*;

  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] alarm_q;
  ctrl_t            ctrl_q;
  logic             status_q;
  logic             irq_q;
  logic             ctrl_wr;
  logic             stat_clr;
  logic             ctrl_unused_bits;

  assign load_wr_o = bus_wr_i && (bus_word_i == WD_LOAD);
  assign ctrl_wr   = bus_wr_i && (bus_word_i == WD_CTRL);
  assign stat_clr  = bus_wr_i && (bus_word_i == WD_STAT) && (bus_wdata_i == '0);
  assign run_set_o = ctrl_wr && bus_wdata_i[CB_RUN];
  assign ctrl_unused_bits = ^{bus_wdata_i[CNT_W-1:CB_STATUS], bus_wdata_i[5:4], bus_wdata_i[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q  <= '0;
      alarm_q <= '0;
      ctrl_q  <= '0;
    end else begin
      if (load_wr_o) load_q <= bus_wdata_i;
      if (bus_wr_i && bus_word_i == WD_ALARM) alarm_q <= bus_wdata_i;
      if (ctrl_wr) begin
        ctrl_q.hold   <= bus_wdata_i[CB_HOLD];
        ctrl_q.div    <= prescale_e'(bus_wdata_i[CB_DIV_LO +: 2]);
        ctrl_q.reload <= bus_wdata_i[CB_RELOAD];
        ctrl_q.run    <= bus_wdata_i[CB_RUN];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= match_i && !(ctrl_q.hold && status_q);
      if (match_i)            status_q <= 1'b1;
      else if (stat_clr)      status_q <= 1'b0;
      else if (!ctrl_q.hold)  status_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (bus_word_i)
      WD_COUNT: bus_rdata_o = count_i;
      WD_CTRL: begin
        bus_rdata_o = '0;
        bus_rdata_o[CB_HOLD]          = ctrl_q.hold;
        bus_rdata_o[CB_DIV_LO +: 2]   = ctrl_q.div;
        bus_rdata_o[CB_RELOAD]        = ctrl_q.reload;
        bus_rdata_o[CB_RUN]           = ctrl_q.run;
        bus_rdata_o[CB_STATUS]        = status_q;
      end
      WD_ALARM: bus_rdata_o = alarm_q;
      default:  bus_rdata_o = load_q;
    endcase
  end

  assign ctrl_o  = ctrl_q;
  assign alarm_o = alarm_q;
  assign irq_o   = irq_q;

  assert_irq_has_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> status_q);

  assert_hold_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.hold && status_q && !stat_clr) |=> status_q);

  assert_hold_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.hold && status_q) |=> !irq_q);

  assert_auto_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.hold && status_q && !match_i) |=> !status_q);

endmodule

// File: rtl/upcount_alarm_timer.sv
module upcount_alarm_timer #(
  parameter int CNT_W     = 32,
  parameter int WORD_W    = 3,
  parameter int MID_LOG2  = 4,
  parameter int SLOW_LOG2 = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_word,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  import upcount_timer_pkg::*;

  ctrl_t            ctrl;
  logic [CNT_W-1:0] alarm;
  logic [CNT_W-1:0] count;
  logic             load_wr;
  logic             run_set;
  logic             active;
  logic             tick;
  logic             match;

  upcount_regs #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr_i    (bus_wr),
    .bus_word_i  (bus_word),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .count_i     (count),
    .match_i     (match),
    .ctrl_o      (ctrl),
    .alarm_o     (alarm),
    .load_wr_o   (load_wr),
    .run_set_o   (run_set),
    .irq_o       (irq)
  );

  upcount_prescaler #(.MID_LOG2(MID_LOG2), .SLOW_LOG2(SLOW_LOG2)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (active),
    .clear_i (load_wr),
    .div_i   (ctrl.div),
    .tick_o  (tick)
  );

  upcount_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .run_i       (ctrl.run),
    .reload_i    (ctrl.reload),
    .load_wr_i   (load_wr),
    .load_data_i (bus_wdata),
    .run_set_i   (run_set),
    .alarm_i     (alarm),
    .count_o     (count),
    .active_o    (active),
    .match_o     (match)
  );

  assert_irq_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq || (count != $past(count)));

endmodule

// File: tb/upcount_alarm_timer_bench.sv
module upcount_alarm_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_word = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq;

  always #2.5 clk = ~clk;

  upcount_alarm_timer u_upcount_alarm_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  int checks = 0;
  int failures = 0;
  string cur_req = "R10";

  // behavioural model state
  longint unsigned m_load, m_count, m_alarm;
  bit m_hold, m_reload, m_run, m_freeze, m_status, m_irq;
  int m_div, m_pre;

  function automatic longint unsigned model_read(input int w);
    case (w)
      1: return m_count;
      2: return (longint'(m_status) << 8) | (longint'(m_run) << 7) |
                (longint'(m_reload) << 6) | (longint'(m_div) << 2) | longint'(m_hold);
      4: return m_alarm;
      default: return m_load;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_load = 0; m_count = 0; m_alarm = 0; m_hold = 0; m_reload = 0; m_run = 0;
      m_freeze = 0; m_status = 0; m_irq = 0; m_div = 0; m_pre = 0;
    end else begin
      bit active, tick, hit, ldw;
      int period;
      ldw = bus_wr && bus_word == 3'd0;
      active = m_run && !m_freeze;
      period = (m_div == 0) ? 1 : (m_div == 1) ? 16 : 256;
      tick = active && !ldw && (m_pre >= period - 1);
      hit = tick && (((m_count + 1) % 64'h1_0000_0000) == m_alarm);
      if (ldw || !active || tick) m_pre = 0; else m_pre = m_pre + 1;
      m_irq = hit && !(m_hold && m_status);
      if (hit) m_status = 1;
      else if (bus_wr && bus_word == 3'd3 && bus_wdata == 0) m_status = 0;
      else if (!m_hold) m_status = 0;
      if (ldw) begin
        m_count = bus_wdata;
        if (bus_wdata != 0) m_freeze = 0;
        else if (m_reload) m_freeze = 1;
      end else if (tick) m_count = (m_count + 1) % 64'h1_0000_0000;
      if (ldw) m_load = bus_wdata;
      if (bus_wr && bus_word == 3'd4) m_alarm = bus_wdata;
      if (bus_wr && bus_word == 3'd2) begin
        m_hold = bus_wdata[0]; m_div = int'(bus_wdata[3:2]);
        m_reload = bus_wdata[6]; m_run = bus_wdata[7];
        if (bus_wdata[7]) m_freeze = 0;
      end
    end
  end

  task automatic compare();
    checks++;
    if (bus_rdata !== 32'(model_read(int'(bus_word)))) begin
      failures++;
      $display("FAIL %s rdata word %0d actual=%h expected=%h", cur_req, bus_word,
               bus_rdata, 32'(model_read(int'(bus_word))));
    end
    checks++;
    if (irq !== m_irq) begin
      failures++;
      $display("FAIL %s irq actual=%b expected=%b", cur_req, irq, m_irq);
    end
  endtask

  task automatic cyc(input bit w, input int word, input logic [31:0] d);
    bus_wr = w; bus_word = 3'(word); bus_wdata = d;
    @(negedge clk);
    compare();
    bus_wr = 1'b0;
  endtask

  task automatic wr(input int word, input logic [31:0] d);
    cyc(1'b1, word, d);
  endtask

  task automatic idle(input int n, input int word);
    for (int i = 0; i < n; i++) cyc(1'b0, word, 32'd0);
  endtask

  task automatic expect_lit(input int word, input logic [31:0] exp, input string req);
    cyc(1'b0, word, 32'd0);
    checks++;
    if (bus_rdata !== exp) begin
      failures++;
      $display("FAIL %s literal word %0d actual=%h expected=%h", req, word, bus_rdata, exp);
    end
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 / R8: reset state over the whole window
    cur_req = "R10";
    for (int w = 0; w < 8; w++) expect_lit(w, 32'd0, "R10");
    checks++;
    if (irq !== 1'b0) begin failures++; $display("FAIL R10 irq actual=%b expected=0", irq); end

    // R8 aliasing and R9 ignored count write
    cur_req = "R8";
    wr(0, 32'h0000_1234);
    for (int w = 3; w < 8; w++) if (w != 4) expect_lit(w, 32'h0000_1234, "R8");
    wr(4, 32'h0000_1239);
    expect_lit(4, 32'h0000_1239, "R8");
    cur_req = "R9";
    wr(1, 32'hDEAD_BEEF);
    expect_lit(1, 32'h0000_1234, "R9");

    // R2 / R3 / R7: run at divide-by-1, non-hold match
    cur_req = "R7";
    wr(2, 32'h80);
    idle(12, 1);
    idle(3, 2);

    // R4: load overwrites live count
    cur_req = "R4";
    wr(0, 32'h0000_1200);
    idle(6, 1);
    wr(0, 32'h0000_1236);
    idle(6, 2);

    // R2 / R3: wrap through zero with alarm at zero
    cur_req = "R2";
    wr(4, 32'h0000_0000);
    wr(0, 32'hFFFF_FFFD);
    idle(6, 1);

    // R1: divide by 16, 256 and code 3
    cur_req = "R1";
    wr(4, 32'h0000_0040);
    wr(2, 32'h84); idle(60, 1);
    wr(2, 32'h88); idle(560, 1);
    wr(2, 32'h8C); idle(560, 1);

    // R6: hold mode
    cur_req = "R6";
    wr(2, 32'h81);
    wr(4, 32'h0000_0105);
    wr(0, 32'h0000_0100);
    idle(8, 2);
    wr(0, 32'h0000_0100);
    idle(8, 1);
    wr(3, 32'h0000_0005);
    idle(2, 2);
    wr(3, 32'h0000_0000);
    idle(2, 2);
    wr(0, 32'h0000_0100);
    idle(8, 2);
    wr(3, 32'h0000_0000);

    // R5: zero load freeze under reload
    cur_req = "R5";
    wr(2, 32'hC0);
    wr(0, 32'h0000_0000);
    idle(10, 1);
    expect_lit(1, 32'h0000_0000, "R5");
    wr(2, 32'hC0);
    idle(5, 1);
    wr(0, 32'h0000_0000);
    idle(4, 1);
    expect_lit(1, 32'h0000_0000, "R5");
    wr(0, 32'h0000_0007);
    idle(5, 1);
    wr(2, 32'h80);
    wr(0, 32'h0000_0000);
    idle(5, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule